// File: doc/BRIEF.md
# JTAG Test Access Port with Debug-Bus Bridge

This block is a JTAG test access port for a chip's debug path. A host drives TCK, TMS, TDI and an active-low TRST. Through the instruction register it selects one of several data registers. Besides a fixed identification register, a one-bit bypass register and a short boundary chain, the port gives indirect access to two on-chip buses. The first is a debug-module port with an 8-bit address and a 64-bit data word. The second is a Wishbone classic master with 16-bit address and data.

Each bus has its own address register, written by a plain data-register scan. A scan with a read instruction ends in Update-DR, which starts a bus read at the stored address. The read result is latched when the slave acknowledges, and the next Capture-DR under a read or write-read instruction shifts it out. A scan with a write-read instruction starts a read of the addressed location and then writes the newly shifted word to it. The old contents therefore come out on a later scan. Everything runs on TCK, and TRST resets all state asynchronously.

Top module: `jtag_dbg_bridge`

## Requirements
- R1: TRST low, or TMS held high for five rising TCK edges, puts the controller in Test-Logic-Reset, and the active instruction becomes 1 (identification).
- R2: The instruction register is 4 bits wide and shifts LSB first. Capture-IR loads 4'b0001, so the bits shifted out during an IR scan read 0x1.
- R3: Instruction 1 selects a 32-bit register that always captures 0x000018FF. Data registers shift LSB first.
- R4: Any code other than 0, 1, 2 and 5 to 10 selects a 1-bit bypass register that captures 0. TDI therefore reaches TDO one shift later.
- R5: Instruction 5 selects the 8-bit debug-port address register, and instruction 8 selects the 16-bit Wishbone address register. Update-DR loads either one, and a later capture returns the stored value.
- R6: With instruction 6, Update-DR starts a debug-port read at the stored address (dmi_req high, dmi_we low). The data is latched on dmi_ack, and a later Capture-DR under instruction 6 or 7 shifts out the 64-bit result.
- R7: With instruction 7, Update-DR starts a read of the addressed location and then a write (dmi_we high) of the 64 bits just shifted in. The value read is what a later capture returns, so the scan that follows a write-read yields the old contents.
- R8: Instructions 9 and 10 do the same as 6 and 7 on the Wishbone port with 16-bit data. wb_cyc and wb_stb stay high together with a stable address until wb_ack, and wb_we is high only in the write phase.
- R9: Instructions 0 and 2 select a boundary chain of BS_LEN bits (8 by default). Update-DR stores it, and the next scan shifts the stored bits back out.
- R10: A bus request, once raised, stays high with a stable address and direction until its acknowledge. No request is active after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, the only clock of the block |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, LSB of the selected shift register while shifting, else 0 |
| dmi_req | output | 1 | Debug-port request, held until acknowledge |
| dmi_we | output | 1 | Debug-port write phase |
| dmi_addr | output | 8 | Debug-port address |
| dmi_wdata | output | 64 | Debug-port write data |
| dmi_rdata | input | 64 | Debug-port read data, sampled with dmi_ack |
| dmi_ack | input | 1 | Debug-port acknowledge |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | 16 | Wishbone address |
| wb_dat_o | output | 16 | Wishbone write data |
| wb_dat_i | input | 16 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
The assertions check on every cycle that five high TMS samples force reset and load the identification instruction. They also check that both bus requests stay up with a steady address and direction until acknowledged, and that a write-read always opens with a read phase. Only the bench scenarios can show the values that come out of each register. This covers the identification code, the bypass delay, address read-back, the old-contents result of a write-read, and the boundary chain that returns what was stored in the previous scan.

// File: rtl/jtag_dbg_pkg.sv
package jtag_dbg_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR,
        ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_READ, PH_WRITE
    } bus_phase_e;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] INS_EXTEST   = 4'd0;
    localparam logic [IR_W-1:0] INS_IDCODE   = 4'd1;
    localparam logic [IR_W-1:0] INS_SAMPLE   = 4'd2;
    localparam logic [IR_W-1:0] INS_DMI_ADDR = 4'd5;
    localparam logic [IR_W-1:0] INS_DMI_RD   = 4'd6;
    localparam logic [IR_W-1:0] INS_DMI_WRRD = 4'd7;
    localparam logic [IR_W-1:0] INS_WB_ADDR  = 4'd8;
    localparam logic [IR_W-1:0] INS_WB_RD    = 4'd9;
    localparam logic [IR_W-1:0] INS_WB_WRRD  = 4'd10;

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_dbg_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    tap_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  state_d = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  state_d = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
            default:   state_d = ST_TLR;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_TLR;
        else         state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/dbg_bus_port.sv
module dbg_bus_port
    import jtag_dbg_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_rd,
    input  logic          start_wrrd,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    input  logic [DW-1:0] rdata_i,
    input  logic          ack_i,
    output logic [DW-1:0] result_o
);

    typedef struct packed {
        bus_phase_e    phase;
        logic          wrrd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] result;
    } port_regs_t;

    port_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_rd || start_wrrd) begin
                    r_d.phase = PH_READ;
                    r_d.wrrd  = start_wrrd;
                    r_d.addr  = addr_i;
                    r_d.wdata = wdata_i;
                end
            end
            PH_READ: begin
                if (ack_i) begin
                    r_d.result = rdata_i;
                    r_d.phase  = r_q.wrrd ? PH_WRITE : PH_IDLE;
                end
            end
            PH_WRITE: begin
                if (ack_i) r_d.phase = PH_IDLE;
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{phase: PH_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign req_o    = (r_q.phase != PH_IDLE);
    assign we_o     = (r_q.phase == PH_WRITE);
    assign addr_o   = r_q.addr;
    assign wdata_o  = r_q.wdata;
    assign result_o = r_q.result;

endmodule

// File: rtl/jtag_dbg_bridge.sv
module jtag_dbg_bridge
    import jtag_dbg_pkg::*;
#(
    parameter int          DMI_AW     = 8,
    parameter int          DMI_DW     = 64,
    parameter int          WB_AW      = 16,
    parameter int          WB_DW      = 16,
    parameter int          BS_LEN     = 8,
    parameter logic [31:0] IDCODE_VAL = 32'h0000_18FF
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              dmi_req,
    output logic              dmi_we,
    output logic [DMI_AW-1:0] dmi_addr,
    output logic [DMI_DW-1:0] dmi_wdata,
    input  logic [DMI_DW-1:0] dmi_rdata,
    input  logic              dmi_ack,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [WB_AW-1:0]  wb_adr,
    output logic [WB_DW-1:0]  wb_dat_o,
    input  logic [WB_DW-1:0]  wb_dat_i,
    input  logic              wb_ack
);

    localparam int W_A   = (DMI_DW > 32) ? DMI_DW : 32;
    localparam int W_B   = (W_A > WB_DW) ? W_A : WB_DW;
    localparam int W_C   = (W_B > BS_LEN) ? W_B : BS_LEN;
    localparam int W_D   = (W_C > WB_AW) ? W_C : WB_AW;
    localparam int DR_W  = (W_D > DMI_AW) ? W_D : DMI_AW;
    localparam int DR_IW = $clog2(DR_W);

    typedef struct packed {
        logic [IR_W-1:0]   ir_sr;
        logic [IR_W-1:0]   ir;
        logic [DR_W-1:0]   dr_sr;
        logic [DMI_AW-1:0] dmi_addr;
        logic [WB_AW-1:0]  wb_addr;
        logic [BS_LEN-1:0] bs;
    } tap_regs_t;

    tap_regs_t r_d, r_q;
    tap_state_e tap_state;
    logic [IR_W-1:0] ir_cur;

    logic dmi_go_rd, dmi_go_wrrd, wb_go_rd, wb_go_wrrd;
    logic [DMI_DW-1:0] dmi_result;
    logic [WB_DW-1:0]  wb_result;
    logic              wb_req;
    logic [DR_IW-1:0]  shift_top;

    function automatic int dr_len(input logic [IR_W-1:0] ins);
        case (ins)
            INS_IDCODE:               return 32;
            INS_DMI_ADDR:             return DMI_AW;
            INS_DMI_RD, INS_DMI_WRRD: return DMI_DW;
            INS_WB_ADDR:              return WB_AW;
            INS_WB_RD, INS_WB_WRRD:   return WB_DW;
            INS_EXTEST, INS_SAMPLE:   return BS_LEN;
            default:                  return 1;
        endcase
    endfunction

    jtag_tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (tap_state)
    );

    assign shift_top = DR_IW'(dr_len(r_q.ir) - 1);

    always_comb begin
        r_d         = r_q;
        dmi_go_rd   = 1'b0;
        dmi_go_wrrd = 1'b0;
        wb_go_rd    = 1'b0;
        wb_go_wrrd  = 1'b0;
        unique case (tap_state)
            ST_TLR:    r_d.ir = INS_IDCODE;
            ST_CAP_IR: r_d.ir_sr = IR_W'(1);
            ST_SH_IR:  r_d.ir_sr = {tdi, r_q.ir_sr[IR_W-1:1]};
            ST_UPD_IR: r_d.ir = r_q.ir_sr;
            ST_CAP_DR: begin
                r_d.dr_sr = '0;
                case (r_q.ir)
                    INS_IDCODE:               r_d.dr_sr[31:0] = IDCODE_VAL;
                    INS_DMI_ADDR:             r_d.dr_sr[DMI_AW-1:0] = r_q.dmi_addr;
                    INS_DMI_RD, INS_DMI_WRRD: r_d.dr_sr[DMI_DW-1:0] = dmi_result;
                    INS_WB_ADDR:              r_d.dr_sr[WB_AW-1:0] = r_q.wb_addr;
                    INS_WB_RD, INS_WB_WRRD:   r_d.dr_sr[WB_DW-1:0] = wb_result;
                    INS_EXTEST, INS_SAMPLE:   r_d.dr_sr[BS_LEN-1:0] = r_q.bs;
                    default:                  r_d.dr_sr = '0;
                endcase
            end
            ST_SH_DR: begin
                r_d.dr_sr = r_q.dr_sr >> 1;
                r_d.dr_sr[shift_top] = tdi;
            end
            ST_UPD_DR: begin
                case (r_q.ir)
                    INS_DMI_ADDR:           r_d.dmi_addr = r_q.dr_sr[DMI_AW-1:0];
                    INS_DMI_RD:             dmi_go_rd = 1'b1;
                    INS_DMI_WRRD:           dmi_go_wrrd = 1'b1;
                    INS_WB_ADDR:            r_d.wb_addr = r_q.dr_sr[WB_AW-1:0];
                    INS_WB_RD:              wb_go_rd = 1'b1;
                    INS_WB_WRRD:            wb_go_wrrd = 1'b1;
                    INS_EXTEST, INS_SAMPLE: r_d.bs = r_q.dr_sr[BS_LEN-1:0];
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{ir: INS_IDCODE, default: '0};
        else         r_q <= r_d;
    end

    dbg_bus_port #(.AW(DMI_AW), .DW(DMI_DW)) u_dmi (
        .clk        (tck),
        .rst_n      (trst_n),
        .start_rd   (dmi_go_rd),
        .start_wrrd (dmi_go_wrrd),
        .addr_i     (r_q.dmi_addr),
        .wdata_i    (r_q.dr_sr[DMI_DW-1:0]),
        .req_o      (dmi_req),
        .we_o       (dmi_we),
        .addr_o     (dmi_addr),
        .wdata_o    (dmi_wdata),
        .rdata_i    (dmi_rdata),
        .ack_i      (dmi_ack),
        .result_o   (dmi_result)
    );

    dbg_bus_port #(.AW(WB_AW), .DW(WB_DW)) u_wb (
        .clk        (tck),
        .rst_n      (trst_n),
        .start_rd   (wb_go_rd),
        .start_wrrd (wb_go_wrrd),
        .addr_i     (r_q.wb_addr),
        .wdata_i    (r_q.dr_sr[WB_DW-1:0]),
        .req_o      (wb_req),
        .we_o       (wb_we),
        .addr_o     (wb_adr),
        .wdata_o    (wb_dat_o),
        .rdata_i    (wb_dat_i),
        .ack_i      (wb_ack),
        .result_o   (wb_result)
    );

    assign wb_cyc = wb_req;
    assign wb_stb = wb_req;
    assign ir_cur = r_q.ir;

    assign tdo = (tap_state == ST_SH_IR) ? r_q.ir_sr[0] :
                 (tap_state == ST_SH_DR) ? r_q.dr_sr[0] : 1'b0;

endmodule

// File: rtl/jtag_dbg_bridge_chk.sv
module jtag_dbg_bridge_chk
    import jtag_dbg_pkg::*;
#(
    parameter int DMI_AW = 8,
    parameter int WB_AW  = 16
) (
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input tap_state_e        state,
    input logic [IR_W-1:0]   ir,
    input logic              dmi_req,
    input logic              dmi_we,
    input logic              dmi_ack,
    input logic [DMI_AW-1:0] dmi_addr,
    input logic              wb_cyc,
    input logic              wb_stb,
    input logic              wb_ack,
    input logic [WB_AW-1:0]  wb_adr
);

    logic [2:0] tms_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        tms_run <= '0;
        else if (!tms)      tms_run <= '0;
        else if (tms_run != 3'd7) tms_run <= tms_run + 3'd1;
    end

    AST_TMS_FORCES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run >= 3'd5) |-> (state == ST_TLR)); // R1

    AST_RESET_LOADS_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (ir == INS_IDCODE)); // R1

    AST_DMI_REQ_HELD: assert property (@(posedge tck) disable iff (!trst_n)
        (dmi_req && !dmi_ack) |=> (dmi_req && $stable(dmi_addr) && $stable(dmi_we))); // R10

    AST_DMI_READ_FIRST: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(dmi_req) |-> !dmi_we); // R7

    AST_WB_CYCLE_HELD: assert property (@(posedge tck) disable iff (!trst_n)
        (wb_cyc && !wb_ack) |=> (wb_cyc && wb_stb && $stable(wb_adr))); // R8

endmodule

bind jtag_dbg_bridge jtag_dbg_bridge_chk #(.DMI_AW(DMI_AW), .WB_AW(WB_AW)) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .state    (tap_state),
    .ir       (ir_cur),
    .dmi_req  (dmi_req),
    .dmi_we   (dmi_we),
    .dmi_ack  (dmi_ack),
    .dmi_addr (dmi_addr),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_ack   (wb_ack),
    .wb_adr   (wb_adr)
);

// File: tb/sim_jtag_dbg_bridge.sv
`timescale 1ns/1ps
module sim_jtag_dbg_bridge;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        dmi_req, dmi_we, dmi_ack = 1'b0;
    logic [7:0]  dmi_addr;
    logic [63:0] dmi_wdata, dmi_rdata = '0;
    logic        wb_cyc, wb_stb, wb_we, wb_ack = 1'b0;
    logic [15:0] wb_adr, wb_dat_o, wb_dat_i = '0;

    int vectors = 0;
    int miscompares = 0;
    logic [63:0] exp_q[$];
    logic [63:0] obs_q[$];
    string       tag_q[$];

    logic [63:0] dmi_mem [256];
    logic [15:0] wb_mem  [256];
    logic [15:0] wb_last_wr_adr = '0, wb_last_wr_dat = '0;

    always #10 tck = ~tck;

    jtag_dbg_bridge u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .dmi_req(dmi_req), .dmi_we(dmi_we), .dmi_addr(dmi_addr),
        .dmi_wdata(dmi_wdata), .dmi_rdata(dmi_rdata), .dmi_ack(dmi_ack),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
    );

    initial begin
        for (int i = 0; i < 256; i++) begin
            dmi_mem[i] = 64'h1234_0000_0000_0000 + 64'(i);
            wb_mem[i]  = 16'h5A00 ^ 16'(i);
        end
    end

    // bus slave models: one-cycle acknowledge
    always @(posedge tck) begin
        dmi_ack <= dmi_req && !dmi_ack;
        if (dmi_req && !dmi_ack) begin
            dmi_rdata <= dmi_mem[dmi_addr];
            if (dmi_we) dmi_mem[dmi_addr] <= dmi_wdata;
        end
        wb_ack <= wb_cyc && wb_stb && !wb_ack;
        if (wb_cyc && wb_stb && !wb_ack) begin
            wb_dat_i <= wb_mem[wb_adr[7:0]];
            if (wb_we) begin
                wb_mem[wb_adr[7:0]] <= wb_dat_o;
                wb_last_wr_adr <= wb_adr;
                wb_last_wr_dat <= wb_dat_o;
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops observed scan results and compares with expectations
    initial begin
        forever begin
            @(negedge tck);
            while (obs_q.size() > 0 && exp_q.size() > 0)
                check(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        o   = tdo;
        tms = m;
        tdi = d;
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, o);
    endtask

    task automatic tms_reset();
        logic o;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] code, input string tag);
        logic o;
        logic [63:0] dout = '0;
        exp_q.push_back(64'h1);
        tag_q.push_back(tag);
        tick(1'b1, 1'b0, o);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, code[i], o);
            dout[i] = o;
        end
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        obs_q.push_back(dout);
        idle(2);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din,
                           input logic [63:0] exp, input string tag);
        logic o;
        logic [63:0] dout = '0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], o);
            dout[i] = o;
        end
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        obs_q.push_back(dout);
        idle(10);
    endtask

    initial begin
        logic [63:0] v1, v2, old10;
        repeat (3) @(negedge tck);
        check("R10 reset dmi_req", 64'(dmi_req), 64'h0);
        check("R10 reset wb_cyc", 64'(wb_cyc), 64'h0);
        check("R1 reset tdo", 64'(tdo), 64'h0);
        trst_n = 1'b1;
        tms = 1'b0;
        idle(2);

        // R1/R3: identification selected straight out of reset
        scan_dr(32, 64'h0, 64'h0000_18FF, "R1 R3 idcode after trst");

        // R2: capture pattern of the instruction register
        scan_ir(4'd6, "R2 ir capture");
        // R1: TMS reset overrides instruction 6
        tms_reset();
        scan_dr(32, 64'hFFFF_FFFF, 64'h0000_18FF, "R1 idcode after tms reset");
        scan_ir(4'd1, "R3 select idcode");
        scan_dr(32, 64'h0, 64'h0000_18FF, "R3 idcode explicit");

        // R4: bypass for unknown codes
        scan_ir(4'hF, "R4 ir code 15");
        scan_dr(9, 64'h16B, 64'h0D6, "R4 bypass code 15");
        scan_ir(4'd3, "R4 ir code 3");
        scan_dr(5, 64'h13, 64'h06, "R4 bypass code 3");

        // R5: debug-port address register
        v1 = dmi_mem[8'h10];
        scan_ir(4'd5, "R2 ir dmi addr");
        scan_dr(8, 64'h10, 64'h00, "R5 dmi addr reset value");
        scan_dr(8, 64'h10, 64'h10, "R5 dmi addr readback");

        // R6: read
        scan_ir(4'd6, "R2 ir dmi read");
        scan_dr(64, 64'h0, 64'h0, "R6 dmi result before any read");
        scan_dr(64, 64'h0, v1, "R6 dmi read data");

        // R7: write-read returns old contents
        scan_ir(4'd7, "R2 ir dmi wrrd");
        scan_dr(64, 64'hCAFE_0000_0000_0001, v1, "R7 dmi first wrrd shift");
        scan_dr(64, 64'hBEEF_0000_0000_0002, v1, "R7 dmi wrrd returns old");
        scan_ir(4'd6, "R2 ir dmi read again");
        scan_dr(64, 64'h0, 64'hCAFE_0000_0000_0001, "R7 dmi wrrd old contents");
        scan_dr(64, 64'h0, 64'hBEEF_0000_0000_0002, "R7 dmi write landed");

        // R8: Wishbone path
        old10 = 64'(wb_mem[8'h18]);
        scan_ir(4'd8, "R2 ir wb addr");
        scan_dr(16, 64'h18, 64'h0, "R5 wb addr reset value");
        scan_dr(16, 64'h18, 64'h18, "R5 wb addr readback");
        scan_ir(4'd10, "R2 ir wb wrrd");
        scan_dr(16, 64'hFEEF, 64'h0, "R8 wb result before access");
        scan_ir(4'd9, "R2 ir wb read");
        scan_dr(16, 64'h0, old10, "R8 wb wrrd old contents");
        scan_dr(16, 64'h0, 64'hFEEF, "R8 wb read after write");
        check("R8 wb write address", 64'(wb_last_wr_adr), 64'h18);
        check("R8 wb write data", 64'(wb_last_wr_dat), 64'hFEEF);

        // R9: boundary chain
        scan_ir(4'd0, "R2 ir extest");
        scan_dr(8, 64'hC3, 64'h00, "R9 chain reset value");
        scan_ir(4'd2, "R2 ir sample");
        scan_dr(8, 64'h5A, 64'hC3, "R9 chain returns stored");
        scan_dr(8, 64'h00, 64'h5A, "R9 chain second store");

        check("R10 bus idle at end", 64'({dmi_req, wb_cyc}), 64'h0);
        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tck);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule